// File: doc/BRIEF.md
# Parallel Sample Packing Input for a Filter Channel Pair

This block sits in front of a pair of digital filter channels and lets a host processor or a DMA engine supply 16-bit two's-complement samples directly, in place of a serial modulator bit stream. Each channel owns one 32-bit input word register. Both the processor and the DMA engine write it through the same port. A 2-bit packing mode sets how the two 16-bit halves of a written word are used.

In single mode, a written word carries one sample in its low half. In sequential-pair mode, one word carries two samples for the same channel, and they are released low half first. In split mode, the word written to channel 0 feeds both channels: the low half goes to channel 0 and the high half goes to channel 1, and both are offered in the same cycle. Channel 1's own register is locked against writes in split mode.

Each channel output is a valid/ready stream of one sample per handshake. A pending sample stays on its output until the filter takes it. A write that lands on a register whose samples have not all been taken replaces them and sets a sticky per-register overrun flag. The packing mode is expected to change only while nothing is pending.

Top module: `hpk_pack_in`

## Requirements
- R1: After a synchronous reset, neither channel output is valid and both overrun flags read 0.
- R2: With pack_mode = 0, a write selects its register with wr_sel (0 for channel 0, 1 for channel 1). The write offers wr_data[15:0] as one sample on that channel's output from the next cycle. wr_data[31:16] is never presented.
- R3: With pack_mode = 1, a write offers two samples on the selected channel: wr_data[15:0] first, then wr_data[31:16] after the first handshake.
- R4: With pack_mode = 2, a write with wr_sel = 0 makes both outputs valid in the next cycle, with ch0_data = wr_data[15:0] and ch1_data = wr_data[31:16].
- R5: With pack_mode = 2, a write with wr_sel = 1 is ignored and no output changes because of it.
- R6: While a channel output is valid and its ready is low, the output stays valid with unchanged data, unless a new write replaces the data.
- R7: A write to a register that still has an untaken sample replaces that sample with the new data. It sets overrun[0] (for wr_sel = 0) or overrun[1] (for wr_sel = 1), which stays set until reset.
- R8: pack_mode = 3 behaves exactly like pack_mode = 0.
- R9: In modes 0 and 1, a write to one channel leaves the other channel's output and overrun flag untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pack_mode | input | 2 | Packing mode: 0 single, 1 sequential pair, 2 split, 3 as 0 |
| wr_en | input | 1 | Write strobe from processor or DMA |
| wr_sel | input | 1 | Target register: 0 channel 0, 1 channel 1 |
| wr_data | input | 32 | Written word: low half [15:0], high half [31:16] |
| ch0_ready | input | 1 | Channel 0 filter accepts the offered sample |
| ch1_ready | input | 1 | Channel 1 filter accepts the offered sample |
| ch0_valid | output | 1 | Channel 0 sample offered |
| ch0_data | output | 16 | Channel 0 sample, two's complement |
| ch1_valid | output | 1 | Channel 1 sample offered |
| ch1_data | output | 16 | Channel 1 sample, two's complement |
| overrun | output | 2 | Sticky overrun flag per register, bit 0 for channel 0 |

## Verification
Each mode runs in its own phase. Writes arrive at pseudo-random times to pseudo-random channels, and each filter's ready is pseudo-random.

- Single-mode and reserved-mode phases show whether the high half leaks out or an extra sample appears.
- Sequential-pair phases separate correct low-then-high ordering from swapped or dropped halves.
- Split phases show whether both halves reach both channels in the same cycle, and whether writes to the locked register stay ignored.
- One phase holds ready mostly low. This drives writes onto pending data, so it distinguishes replacement with a sticky flag from queuing or silent loss.

// File: rtl/hpk_pkg.sv
package hpk_pkg;
    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 2 * SAMPLE_W;
    localparam int N_CH     = 2;

    typedef enum logic [1:0] {
        PK_SINGLE   = 2'd0,
        PK_PAIR_SEQ = 2'd1,
        PK_SPLIT    = 2'd2,
        PK_RSVD     = 2'd3
    } pack_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] lo;
        logic [SAMPLE_W-1:0] hi;
        logic                lo_pend;
        logic                hi_pend;
        pack_mode_e          kind;
    } slot_t;

    function automatic pack_mode_e norm_mode(input logic [1:0] raw);
        pack_mode_e m;
        m = pack_mode_e'(raw);
        if (m == PK_RSVD) m = PK_SINGLE;
        return m;
    endfunction
endpackage

// File: rtl/hpk_wdec.sv
module hpk_wdec
    import hpk_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [1:0]        mode_raw,
    output pack_mode_e        kind,
    output logic [N_CH-1:0]   load,
    output logic [N_CH-1:0]   flush
);
    logic split;

    always_comb begin
        kind  = norm_mode(mode_raw);
        split = (kind == PK_SPLIT);
        load[0]  = wr_en & ~wr_sel;
        load[1]  = wr_en & wr_sel & ~split;
        flush[0] = 1'b0;
        flush[1] = wr_en & ~wr_sel & split;
    end
endmodule

// File: rtl/hpk_slot.sv
module hpk_slot
    import hpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              flush,
    input  pack_mode_e        load_kind,
    input  logic [WORD_W-1:0] load_word,
    input  logic              pop_lo,
    input  logic              pop_hi,
    output slot_t             st,
    output logic              overrun
);
    slot_t st_nx;
    logic  ovr_nx;
    logic  left_lo, left_hi;

    always_comb begin
        left_lo = st.lo_pend & ~pop_lo;
        left_hi = st.hi_pend & ~pop_hi;
        st_nx   = st;
        ovr_nx  = overrun;
        st_nx.lo_pend = left_lo;
        st_nx.hi_pend = left_hi;
        if (load) begin
            st_nx.lo      = load_word[SAMPLE_W-1:0];
            st_nx.lo_pend = 1'b1;
            st_nx.kind    = load_kind;
            if (load_kind != PK_SINGLE) begin
                st_nx.hi      = load_word[WORD_W-1:SAMPLE_W];
                st_nx.hi_pend = 1'b1;
            end else begin
                st_nx.hi_pend = 1'b0;
            end
            if (left_lo | left_hi) ovr_nx = 1'b1;
        end else if (flush) begin
            st_nx.lo_pend = 1'b0;
            st_nx.hi_pend = 1'b0;
            if (left_lo | left_hi) ovr_nx = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            overrun <= 1'b0;
        end else begin
            st      <= st_nx;
            overrun <= ovr_nx;
        end
    end
endmodule

// File: rtl/hpk_route.sv
module hpk_route
    import hpk_pkg::*;
(
    input  slot_t                s0,
    input  slot_t                s1,
    input  logic                 rdy0,
    input  logic                 rdy1,
    output logic                 v0,
    output logic [SAMPLE_W-1:0]  d0,
    output logic                 v1,
    output logic [SAMPLE_W-1:0]  d1,
    output logic [N_CH-1:0]      pop_lo,
    output logic [N_CH-1:0]      pop_hi
);
    logic split_hi;
    logic s1_seq_hi;

    always_comb begin
        split_hi  = s0.hi_pend & (s0.kind == PK_SPLIT);
        s1_seq_hi = s1.hi_pend & (s1.kind == PK_PAIR_SEQ);

        v0 = s0.lo_pend | (s0.hi_pend & (s0.kind == PK_PAIR_SEQ));
        d0 = s0.lo_pend ? s0.lo : s0.hi;

        v1 = split_hi | s1.lo_pend | s1_seq_hi;
        if (split_hi)        d1 = s0.hi;
        else if (s1.lo_pend) d1 = s1.lo;
        else                 d1 = s1.hi;

        pop_lo[0] = v0 & rdy0 & s0.lo_pend;
        pop_hi[0] = (v0 & rdy0 & ~s0.lo_pend) | (split_hi & rdy1);
        pop_lo[1] = ~split_hi & rdy1 & s1.lo_pend;
        pop_hi[1] = ~split_hi & rdy1 & ~s1.lo_pend & s1_seq_hi;
    end
endmodule

// File: rtl/hpk_pack_in.sv
module hpk_pack_in
    import hpk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          pack_mode,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                ch0_ready,
    input  logic                ch1_ready,
    output logic                ch0_valid,
    output logic [SAMPLE_W-1:0] ch0_data,
    output logic                ch1_valid,
    output logic [SAMPLE_W-1:0] ch1_data,
    output logic [N_CH-1:0]     overrun
);
    pack_mode_e        kind;
    logic [N_CH-1:0]   load, flush, pop_lo, pop_hi;
    slot_t             slots [N_CH];

    hpk_wdec u_wdec (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .mode_raw (pack_mode),
        .kind     (kind),
        .load     (load),
        .flush    (flush)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_slot
        hpk_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .load      (load[c]),
            .flush     (flush[c]),
            .load_kind (kind),
            .load_word (wr_data),
            .pop_lo    (pop_lo[c]),
            .pop_hi    (pop_hi[c]),
            .st        (slots[c]),
            .overrun   (overrun[c])
        );
    end

    hpk_route u_route (
        .s0     (slots[0]),
        .s1     (slots[1]),
        .rdy0   (ch0_ready),
        .rdy1   (ch1_ready),
        .v0     (ch0_valid),
        .d0     (ch0_data),
        .v1     (ch1_valid),
        .d1     (ch1_data),
        .pop_lo (pop_lo),
        .pop_hi (pop_hi)
    );
endmodule

// File: rtl/hpk_pack_in_chk.sv
module hpk_pack_in_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  pack_mode,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic        ch0_ready,
    input logic        ch1_ready,
    input logic        ch0_valid,
    input logic [15:0] ch0_data,
    input logic        ch1_valid,
    input logic [15:0] ch1_data,
    input logic [1:0]  overrun
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!ch0_valid && !ch1_valid && overrun == 2'b00));

    assert_single_low_R2: assert property (@(posedge clk) disable iff (rst)
        (pack_mode == 2'd0 && wr_en && !wr_sel) |=> (ch0_valid && ch0_data == $past(wr_data[15:0])));

    assert_pair_first_R3: assert property (@(posedge clk) disable iff (rst)
        (pack_mode == 2'd1 && wr_en && wr_sel) |=> (ch1_valid && ch1_data == $past(wr_data[15:0])));

    assert_split_both_R4: assert property (@(posedge clk) disable iff (rst)
        (pack_mode == 2'd2 && wr_en && !wr_sel) |=>
        (ch0_valid && ch1_valid && ch0_data == $past(wr_data[15:0]) && ch1_data == $past(wr_data[31:16])));

    assert_locked_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (pack_mode == 2'd2 && wr_en && wr_sel && !ch0_valid && !ch1_valid) |=> (!ch0_valid && !ch1_valid));

    assert_hold_ch0_R6: assert property (@(posedge clk) disable iff (rst)
        (ch0_valid && !ch0_ready && !(wr_en && !wr_sel)) |=> (ch0_valid && $stable(ch0_data)));

    assert_hold_ch1_R6: assert property (@(posedge clk) disable iff (rst)
        (ch1_valid && !ch1_ready && !wr_en) |=> (ch1_valid && $stable(ch1_data)));

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (rst)
        (ch0_valid && !ch0_ready && wr_en && !wr_sel) |=> overrun[0]);

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (overrun[0] && !$isunknown(overrun)) |=> overrun[0]);

    assert_rsvd_single_R8: assert property (@(posedge clk) disable iff (rst)
        (pack_mode == 2'd3 && wr_en && wr_sel) |=> (ch1_valid && ch1_data == $past(wr_data[15:0])));
endmodule

bind hpk_pack_in hpk_pack_in_chk u_chk (.*);

// File: tb/hpk_pack_in_tb.sv
module hpk_pack_in_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  pack_mode;
    logic        wr_en, wr_sel;
    logic [31:0] wr_data;
    logic        ch0_ready, ch1_ready;
    logic        ch0_valid, ch1_valid;
    logic [15:0] ch0_data, ch1_data;
    logic [1:0]  overrun;

    int checks = 0;
    int errors = 0;
    logic [15:0] q0[$];
    logic [15:0] q1[$];
    logic [1:0]  m_ovr;
    logic [15:0] lfsr = 16'hACE1;
    string       tag;

    always #2 clk = ~clk;

    hpk_pack_in u_dut (
        .clk(clk), .rst(rst), .pack_mode(pack_mode), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ch0_ready(ch0_ready), .ch1_ready(ch1_ready),
        .ch0_valid(ch0_valid), .ch0_data(ch0_data), .ch1_valid(ch1_valid),
        .ch1_data(ch1_data), .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(tag, {31'd0, ch0_valid}, {31'd0, q0.size() > 0}, "ch0_valid (R6)");
        check(tag, {31'd0, ch1_valid}, {31'd0, q1.size() > 0}, "ch1_valid (R6)");
        if (q0.size() > 0) check(tag, {16'd0, ch0_data}, {16'd0, q0[0]}, "ch0_data (R6)");
        if (q1.size() > 0) check(tag, {16'd0, ch1_data}, {16'd0, q1[0]}, "ch1_data (R6)");
        check("R7", {30'd0, overrun}, {30'd0, m_ovr}, "overrun");
    endtask

    task automatic model(input logic w, input logic sel, input logic [31:0] d,
                         input logic [1:0] mode, input logic r0, input logic r1);
        logic [1:0] m;
        if (q0.size() > 0 && r0) void'(q0.pop_front());
        if (q1.size() > 0 && r1) void'(q1.pop_front());
        if (w) begin
            m = (mode == 2'd3) ? 2'd0 : mode;
            if (m == 2'd2) begin
                if (!sel) begin
                    if (q0.size() > 0 || q1.size() > 0) m_ovr[0] = 1'b1;
                    q0 = '{d[15:0]};
                    q1 = '{d[31:16]};
                end
            end else if (!sel) begin
                if (q0.size() > 0) m_ovr[0] = 1'b1;
                if (m == 2'd1) q0 = '{d[15:0], d[31:16]}; else q0 = '{d[15:0]};
            end else begin
                if (q1.size() > 0) m_ovr[1] = 1'b1;
                if (m == 2'd1) q1 = '{d[15:0], d[31:16]}; else q1 = '{d[15:0]};
            end
        end
    endtask

    task automatic cycle(input logic w, input logic sel, input logic [31:0] d,
                         input logic r0, input logic r1);
        compare();
        wr_en = w; wr_sel = sel; wr_data = d; ch0_ready = r0; ch1_ready = r1;
        model(w, sel, d, pack_mode, r0, r1);
        @(negedge clk);
    endtask

    task automatic run_phase(input logic [1:0] mode, input string t, input int n, input logic slow);
        pack_mode = mode;
        tag = t;
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[2:0] == 3'd0, lfsr[7], {lfsr, lfsr ^ 16'h5A3C ^ 16'(i)},
                  slow ? (lfsr[4] & lfsr[5] & lfsr[9]) : (lfsr[4] | lfsr[5]),
                  slow ? (lfsr[6] & lfsr[8] & lfsr[11]) : (lfsr[6] | lfsr[8]));
        end
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, 32'd0, 1'b1, 1'b1);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; pack_mode = 2'd0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        ch0_ready = 1'b0; ch1_ready = 1'b0; m_ovr = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", {31'd0, ch0_valid}, 32'd0, "ch0_valid after reset");
        check("R1", {31'd0, ch1_valid}, 32'd0, "ch1_valid after reset");
        check("R1", {30'd0, overrun}, 32'd0, "overrun after reset");
        tag = "R2";
        cycle(1'b1, 1'b0, 32'hBEEF_1234, 1'b0, 1'b0);
        check("R2", {16'd0, ch0_data}, 32'h1234, "single low half");
        cycle(1'b0, 1'b0, 32'd0, 1'b1, 1'b0);
        check("R2", {31'd0, ch0_valid}, 32'd0, "high half never presented");
        tag = "R4 R5";
        pack_mode = 2'd2;
        cycle(1'b1, 1'b1, 32'h1111_2222, 1'b0, 1'b0);
        check("R5", {30'd0, ch1_valid, ch0_valid}, 32'd0, "locked write ignored");
        cycle(1'b1, 1'b0, 32'h8001_7FFF, 1'b0, 1'b0);
        check("R4", {ch1_data, ch0_data}, 32'h8001_7FFF, "split halves same cycle");
        cycle(1'b0, 1'b0, 32'd0, 1'b1, 1'b1);
        run_phase(2'd0, "R2 R9", 400, 1'b0);
        run_phase(2'd1, "R3 R9", 400, 1'b0);
        run_phase(2'd2, "R4 R5", 400, 1'b0);
        run_phase(2'd3, "R8", 400, 1'b0);
        run_phase(2'd1, "R7", 400, 1'b1);
        compare();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule